// File: doc/BRIEF.md
# Phasing-Method Single-Sideband Upconverter

This block produces single-sideband samples by quadrature mixing. A baseband tone and a faster carrier are each read as a sine and a cosine term from one shared signed sine table. The cosine term is the negated table entry a quarter of the table ahead. The two cross products are subtracted to give one sideband. The difference is normalised, then scaled by an amplitude envelope that the block receives on an input. The result is offered in two forms: a signed sample, and an unsigned 8-bit value centred at mid-scale that can feed a parallel DAC.

Inside the block a position counter runs across one symbol period, which is a number of passes of a fixed number of samples each. The carrier index steps at a fixed rate within each pass and restarts at the start of every pass. The tone index is the symbol position divided by a fixed divisor. A phase-select bit flips the tone by half a table turn, which is 180°. The position only moves on cycles where the enable is high. An upstream sequencer chooses the phase and the envelope value for each sample. This block does not sequence symbols or build envelope ramps.

Top module: `ssb_upconv`

## Requirements
- R1: While reset is asserted and after it is released, `sample_valid` is 0, `ssb_out` is 0 and `dac_out` is 127, until the first enabled sample comes out.
- R2: A sample accepted at a rising edge where `en` is 1 appears at the second rising edge that follows, with `sample_valid` high for exactly that one cycle. At the other edges `sample_valid` is 0.
- R3: An edge where `en` is 0 does not move the symbol position, the carrier index or the tone index.
- R4: Table entry i is round(sin(2πi/128)·1024), with halves rounded away from zero. A cosine term is the negated entry at (index+32) mod 128.
- R5: For sample position p within the symbol, the carrier index is ((p mod PASS_LEN)·8) mod 128.
- R6: The tone index is (floor(p/(BIT_PASSES·TONE_SUB)) + 64·phase_sel) mod 128. `phase_sel` is sampled on the same edge as the sample.
- R7: The position p restarts at 0 after PASS_LEN·BIT_PASSES enabled samples.
- R8: The raw sideband value is floor((cs·tc − cc·ts)/1024). Here cs and cc are the carrier sine and cosine terms, and ts and tc are the tone sine and cosine terms.
- R9: `ssb_out` is floor(raw·e/1024), where e is `env_mag` sampled with the sample. An `env_mag` above 1024 acts as 1024, and 0 gives a zero output.
- R10: `dac_out` is floor(ssb_out/8)+127, clamped to 0..255.
- R11: |`ssb_out`| never exceeds 1025.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Accept one sample this edge and advance the position |
| phase_sel | input | 1 | Tone phase: 0 = 0°, 1 = 180° |
| env_mag | input | 11 | Envelope magnitude, 1024 = unity |
| ssb_out | output | 12 | Signed sideband sample |
| dac_out | output | 8 | Unsigned DAC code, mid-scale 127 |
| sample_valid | output | 1 | One-cycle strobe marking a new sample on both outputs |

## Verification
The bench keeps the full 128-entry table and the carrier step of 8. It shrinks the symbol to 3 passes of 64 samples with a tone divisor of 3, so a symbol lasts 192 samples. In one symbol the tone index therefore sweeps half the table, and with the phase bit set it sweeps the other half. Every carrier index is visited in every pass, and the symbol restart comes up every 192 samples. That makes every table entry, both phases, repeated restarts and the low-end DAC clamp reachable within a few thousand cycles. Envelope values of 0, 1, half, unity and over-range are each run.

// File: rtl/ssb_pkg.sv
package ssb_pkg;

   // read-port slots of the shared sine table
   localparam int P_CAR_SIN  = 0;
   localparam int P_CAR_COS  = 1;
   localparam int P_TONE_SIN = 2;
   localparam int P_TONE_COS = 3;
   localparam int N_PORTS    = 4;

   // round(sin(2*pi*idx/depth) * amp), evaluated by series expansion
   function automatic int sine_entry(input int idx, input int depth, input int amp);
      real pi;
      real th;
      real term;
      real acc;
      pi = 3.14159265358979323846;
      th = 2.0 * pi * idx / depth;
      if (th > pi) th = th - 2.0 * pi;
      if (th > pi / 2.0) th = pi - th;
      else if (th < -pi / 2.0) th = -pi - th;
      term = th;
      acc  = th;
      for (int n = 1; n < 11; n++) begin
         term = -term * th * th / ((2 * n) * (2 * n + 1));
         acc  = acc + term;
      end
      acc = acc * amp;
      if (acc >= 0.0) return $rtoi(acc + 0.5);
      else return -$rtoi(0.5 - acc);
   endfunction

endpackage

// File: rtl/ssb_sine_rom.sv
module ssb_sine_rom #(
   parameter int DEPTH     = 128,
   parameter int AMP_SHIFT = 10,
   parameter int NPORT     = 4,
   localparam int IDX_W    = $clog2(DEPTH),
   localparam int VAL_W    = AMP_SHIFT + 2
) (
   input  logic [NPORT-1:0][IDX_W-1:0] rd_idx,
   output logic [NPORT-1:0][VAL_W-1:0] rd_val
);

   localparam int AMP = 1 << AMP_SHIFT;

   logic [VAL_W-1:0] tbl [DEPTH];

   for (genvar g = 0; g < DEPTH; g++) begin : g_entry
      assign tbl[g] = VAL_W'(ssb_pkg::sine_entry(g, DEPTH, AMP));
   end

   for (genvar p = 0; p < NPORT; p++) begin : g_port
      assign rd_val[p] = tbl[rd_idx[p]];
   end

endmodule

// File: rtl/ssb_phase_gen.sv
module ssb_phase_gen #(
   parameter int DEPTH      = 128,
   parameter int CAR_STEP   = 8,
   parameter int PASS_LEN   = 4096,
   parameter int BIT_PASSES = 313,
   parameter int TONE_SUB   = 8,
   localparam int IDX_W     = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             phase_sel,
   output logic [IDX_W-1:0] car_idx,
   output logic [IDX_W-1:0] tone_idx
);

   localparam int TONE_DIV = BIT_PASSES * TONE_SUB;
   localparam int SMP_W    = $clog2(PASS_LEN);
   localparam int PAS_W    = $clog2(BIT_PASSES);
   localparam int REM_W    = $clog2(TONE_DIV);
   localparam logic [IDX_W-1:0] STEP = IDX_W'(CAR_STEP);
   localparam logic [IDX_W-1:0] HALF = IDX_W'(DEPTH / 2);

   logic [SMP_W-1:0] smp_q;
   logic [PAS_W-1:0] pas_q;
   logic [REM_W-1:0] rem_q;
   logic [IDX_W-1:0] car_q;
   logic [IDX_W-1:0] tone_q;

   logic pass_last, bit_last, rem_last;

   assign pass_last = (smp_q == SMP_W'(PASS_LEN - 1));
   assign bit_last  = pass_last && (pas_q == PAS_W'(BIT_PASSES - 1));
   assign rem_last  = (rem_q == REM_W'(TONE_DIV - 1));

   // sample within pass and carrier index
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         smp_q <= '0;
         car_q <= '0;
      end else if (en) begin
         if (pass_last) begin
            smp_q <= '0;
            car_q <= '0;
         end else begin
            smp_q <= smp_q + 1'b1;
            car_q <= car_q + STEP;
         end
      end
   end

   // pass within symbol
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pas_q <= '0;
      else if (en && pass_last) pas_q <= bit_last ? '0 : pas_q + 1'b1;
   end

   // tone index: symbol position divided by TONE_DIV
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem_q  <= '0;
         tone_q <= '0;
      end else if (en) begin
         if (bit_last) begin
            rem_q  <= '0;
            tone_q <= '0;
         end else if (rem_last) begin
            rem_q  <= '0;
            tone_q <= tone_q + 1'b1;
         end else begin
            rem_q <= rem_q + 1'b1;
         end
      end
   end

   assign car_idx  = car_q;
   assign tone_idx = tone_q + (phase_sel ? HALF : '0);

   a_r3_hold_when_idle : assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> $stable(car_q) && $stable(tone_q) && $stable(smp_q) && $stable(rem_q));

   a_r5_carrier_step : assert property (@(posedge clk) disable iff (!rst_n)
      en && !pass_last |=> car_q == IDX_W'($past(car_q) + STEP));

   a_r6_tone_monotone : assert property (@(posedge clk) disable iff (!rst_n)
      en && !bit_last |=> IDX_W'(tone_q - $past(tone_q)) <= IDX_W'(1));

   a_r7_symbol_restart : assert property (@(posedge clk) disable iff (!rst_n)
      en && bit_last |=> car_q == '0 && tone_q == '0 && smp_q == '0 && pas_q == '0);

endmodule

// File: rtl/ssb_mixer.sv
module ssb_mixer #(
   parameter int AMP_SHIFT = 10,
   parameter int ENV_W     = 11,
   parameter int OUT_W     = 12,
   parameter int DAC_W     = 8,
   parameter int DAC_SHIFT = 3,
   localparam int VAL_W    = AMP_SHIFT + 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    en,
   input  logic signed [VAL_W-1:0] car_sin,
   input  logic signed [VAL_W-1:0] car_cos_raw,
   input  logic signed [VAL_W-1:0] tone_sin,
   input  logic signed [VAL_W-1:0] tone_cos_raw,
   input  logic [ENV_W-1:0]        env_mag,
   output logic signed [OUT_W-1:0] ssb_out,
   output logic [DAC_W-1:0]        dac_out,
   output logic                    sample_valid
);

   localparam int AMP    = 1 << AMP_SHIFT;
   localparam int PROD_W = 2 * VAL_W + 1;
   localparam int RAW_W  = VAL_W;
   localparam int EEF_W  = AMP_SHIFT + 1;
   localparam int SCL_W  = RAW_W + EEF_W + 1;
   localparam int DAC_MID = (1 << (DAC_W - 1)) - 1;
   localparam int DAC_TOP = (1 << DAC_W) - 1;
   localparam logic signed [OUT_W:0] MID_S = (OUT_W + 1)'(DAC_MID);
   localparam logic signed [OUT_W:0] TOP_S = (OUT_W + 1)'(DAC_TOP);

   // stage 1: quadrature product difference
   logic signed [VAL_W-1:0]  car_cos, tone_cos;
   logic signed [PROD_W-1:0] diff;
   logic signed [RAW_W-1:0]  raw_d, raw_q;
   logic [EEF_W-1:0]         env_d, env_q;
   logic                     v1_q;

   assign car_cos  = -car_cos_raw;
   assign tone_cos = -tone_cos_raw;
   assign diff = PROD_W'(car_sin) * PROD_W'(tone_cos) - PROD_W'(car_cos) * PROD_W'(tone_sin);
   assign raw_d = RAW_W'(diff >>> AMP_SHIFT);
   assign env_d = (env_mag > ENV_W'(AMP)) ? EEF_W'(AMP) : EEF_W'(env_mag);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         raw_q <= '0;
         env_q <= '0;
         v1_q  <= 1'b0;
      end else begin
         v1_q <= en;
         if (en) begin
            raw_q <= raw_d;
            env_q <= env_d;
         end
      end
   end

   // stage 2: envelope scaling and DAC mapping
   logic signed [SCL_W-1:0] scaled;
   logic signed [OUT_W-1:0] ssb_d, ssb_q;
   logic signed [OUT_W:0]   ssb_x, dac_sh;
   logic [DAC_W-1:0]        dac_d, dac_q;
   logic                    valid_q;

   assign scaled = SCL_W'(raw_q) * SCL_W'($signed({1'b0, env_q}));
   assign ssb_d  = OUT_W'(scaled >>> AMP_SHIFT);
   assign ssb_x  = {ssb_d[OUT_W-1], ssb_d};
   assign dac_sh = (ssb_x >>> DAC_SHIFT) + MID_S;

   always_comb begin
      if (dac_sh < 0) dac_d = '0;
      else if (dac_sh > TOP_S) dac_d = DAC_W'(DAC_TOP);
      else dac_d = DAC_W'(dac_sh);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ssb_q   <= '0;
         dac_q   <= DAC_W'(DAC_MID);
         valid_q <= 1'b0;
      end else begin
         valid_q <= v1_q;
         if (v1_q) begin
            ssb_q <= ssb_d;
            dac_q <= dac_d;
         end
      end
   end

   assign ssb_out      = ssb_q;
   assign dac_out      = dac_q;
   assign sample_valid = valid_q;

   a_r2_valid_latency : assert property (@(posedge clk) disable iff (!rst_n)
      en |-> ##2 valid_q);

   a_r2_no_spurious_valid : assert property (@(posedge clk) disable iff (!rst_n)
      !en |-> ##2 !valid_q);

   a_r9_zero_envelope : assert property (@(posedge clk) disable iff (!rst_n)
      en && env_mag == '0 |-> ##2 ssb_q == '0);

   a_r10_dac_side : assert property (@(posedge clk) disable iff (!rst_n)
      valid_q |-> (ssb_q >= 0) == (dac_q >= DAC_W'(DAC_MID)));

   a_r11_magnitude : assert property (@(posedge clk) disable iff (!rst_n)
      valid_q |-> (int'(ssb_q) <= AMP + 1) && (int'(ssb_q) >= -(AMP + 1)));

endmodule

// File: rtl/ssb_upconv.sv
module ssb_upconv #(
   parameter int TBL_DEPTH  = 128,
   parameter int AMP_SHIFT  = 10,
   parameter int CAR_STEP   = 8,
   parameter int PASS_LEN   = 4096,
   parameter int BIT_PASSES = 313,
   parameter int TONE_SUB   = 8,
   parameter int ENV_W      = 11,
   parameter int OUT_W      = 12,
   parameter int DAC_W      = 8,
   parameter int DAC_SHIFT  = 3
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    en,
   input  logic                    phase_sel,
   input  logic [ENV_W-1:0]        env_mag,
   output logic signed [OUT_W-1:0] ssb_out,
   output logic [DAC_W-1:0]        dac_out,
   output logic                    sample_valid
);

   localparam int IDX_W = $clog2(TBL_DEPTH);
   localparam int VAL_W = AMP_SHIFT + 2;
   localparam logic [IDX_W-1:0] QTR = IDX_W'(TBL_DEPTH / 4);

   // elaboration-time parameter checks
   if (TBL_DEPTH < 8 || (TBL_DEPTH & (TBL_DEPTH - 1)) != 0) begin : g_chk_depth
      $error("TBL_DEPTH must be a power of two of at least 8");
   end
   if (CAR_STEP < 1 || CAR_STEP >= TBL_DEPTH) begin : g_chk_step
      $error("CAR_STEP must lie in 1..TBL_DEPTH-1");
   end
   if (PASS_LEN < 2 || BIT_PASSES < 2 || TONE_SUB < 1) begin : g_chk_timing
      $error("PASS_LEN and BIT_PASSES need at least 2, TONE_SUB at least 1");
   end
   if (ENV_W < AMP_SHIFT + 1) begin : g_chk_env
      $error("ENV_W must hold the unity envelope value");
   end
   if (OUT_W < AMP_SHIFT + 2 || OUT_W + 1 <= DAC_W) begin : g_chk_out
      $error("OUT_W too narrow for the sample or the DAC mapping");
   end

   logic [IDX_W-1:0] car_idx, tone_idx;
   logic [ssb_pkg::N_PORTS-1:0][IDX_W-1:0] rd_idx;
   logic [ssb_pkg::N_PORTS-1:0][VAL_W-1:0] rd_val;

   ssb_phase_gen #(
      .DEPTH      (TBL_DEPTH),
      .CAR_STEP   (CAR_STEP),
      .PASS_LEN   (PASS_LEN),
      .BIT_PASSES (BIT_PASSES),
      .TONE_SUB   (TONE_SUB)
   ) u_phase (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (en),
      .phase_sel (phase_sel),
      .car_idx   (car_idx),
      .tone_idx  (tone_idx)
   );

   assign rd_idx[ssb_pkg::P_CAR_SIN]  = car_idx;
   assign rd_idx[ssb_pkg::P_CAR_COS]  = car_idx + QTR;
   assign rd_idx[ssb_pkg::P_TONE_SIN] = tone_idx;
   assign rd_idx[ssb_pkg::P_TONE_COS] = tone_idx + QTR;

   ssb_sine_rom #(
      .DEPTH     (TBL_DEPTH),
      .AMP_SHIFT (AMP_SHIFT),
      .NPORT     (ssb_pkg::N_PORTS)
   ) u_rom (
      .rd_idx (rd_idx),
      .rd_val (rd_val)
   );

   ssb_mixer #(
      .AMP_SHIFT (AMP_SHIFT),
      .ENV_W     (ENV_W),
      .OUT_W     (OUT_W),
      .DAC_W     (DAC_W),
      .DAC_SHIFT (DAC_SHIFT)
   ) u_mix (
      .clk          (clk),
      .rst_n        (rst_n),
      .en           (en),
      .car_sin      ($signed(rd_val[ssb_pkg::P_CAR_SIN])),
      .car_cos_raw  ($signed(rd_val[ssb_pkg::P_CAR_COS])),
      .tone_sin     ($signed(rd_val[ssb_pkg::P_TONE_SIN])),
      .tone_cos_raw ($signed(rd_val[ssb_pkg::P_TONE_COS])),
      .env_mag      (env_mag),
      .ssb_out      (ssb_out),
      .dac_out      (dac_out),
      .sample_valid (sample_valid)
   );

endmodule

// File: tb/tb_ssb_upconv.sv
`timescale 1ns/1ps
module tb_ssb_upconv;

   localparam int PASS_LEN   = 64;
   localparam int BIT_PASSES = 3;
   localparam int TONE_SUB   = 1;
   localparam int SYM_LEN    = PASS_LEN * BIT_PASSES;
   localparam int DIVISOR    = BIT_PASSES * TONE_SUB;
   localparam int LOG_N      = 4096;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic en = 1'b0;
   logic phase_sel = 1'b0;
   logic [10:0] env_mag = '0;
   logic signed [11:0] ssb_out;
   logic [7:0] dac_out;
   logic sample_valid;

   always #2.5 clk = ~clk;

   ssb_upconv #(
      .PASS_LEN   (PASS_LEN),
      .BIT_PASSES (BIT_PASSES),
      .TONE_SUB   (TONE_SUB)
   ) dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .en           (en),
      .phase_sel    (phase_sel),
      .env_mag      (env_mag),
      .ssb_out      (ssb_out),
      .dac_out      (dac_out),
      .sample_valid (sample_valid)
   );

   int tests = 0;
   int fails = 0;
   int tbl [128];
   bit ph_log [LOG_N];
   int env_log [LOG_N];
   int n_in = 0;
   int n_out = 0;
   bit d1 = 1'b0;
   bit d2 = 1'b0;

   // R4 table computed from the requirement
   function automatic int tab(input int i);
      real v;
      v = $sin(2.0 * 3.14159265358979323846 * i / 128.0) * 1024.0;
      if (v >= 0.0) return $rtoi(v + 0.5);
      else return -$rtoi(0.5 - v);
   endfunction

   function automatic int exp_ssb(input int n, input bit ph, input int env);
      int pos, cidx, tidx, cs, cc, ts, tc, d, raw, e;
      pos  = n % SYM_LEN;
      cidx = ((pos % PASS_LEN) * 8) % 128;
      tidx = (pos / DIVISOR + (ph ? 64 : 0)) % 128;
      cs = tbl[cidx];
      cc = -tbl[(cidx + 32) % 128];
      ts = tbl[tidx];
      tc = -tbl[(tidx + 32) % 128];
      d   = cs * tc - cc * ts;
      raw = d >>> 10;
      e   = (env > 1024) ? 1024 : env;
      return (raw * e) >>> 10;
   endfunction

   function automatic int exp_dac(input int s);
      int t;
      t = (s >>> 3) + 127;
      if (t < 0) t = 0;
      if (t > 255) t = 255;
      return t;
   endfunction

   task automatic check(input string tag, input int act, input int expv);
      tests++;
      if (act != expv) begin
         fails++;
         $display("FAIL %s sample %0d: actual %0d expected %0d", tag, n_out, act, expv);
      end
   endtask

   // one cycle: check what the last edge produced, then drive the next sample
   task automatic step(input bit e, input bit ph, input int env, input string tag);
      @(negedge clk);
      check("R2 valid", int'(sample_valid), int'(d2));
      if (d2 && sample_valid) begin
         check({tag, " ssb"}, int'(ssb_out),
               exp_ssb(n_out, ph_log[n_out], env_log[n_out]));
         check("R10 dac", int'(dac_out),
               exp_dac(exp_ssb(n_out, ph_log[n_out], env_log[n_out])));
         n_out++;
      end
      d2 = d1;
      d1 = e;
      en = e;
      phase_sel = ph;
      env_mag = 11'(env);
      if (e) begin
         ph_log[n_in]  = ph;
         env_log[n_in] = env;
         n_in++;
      end
   endtask

   task automatic run(input bit ph, input int env, input int cnt, input string tag);
      for (int k = 0; k < cnt; k++) step(1'b1, ph, env, tag);
   endtask

   initial begin
      for (int i = 0; i < 128; i++) tbl[i] = tab(i);
      repeat (3) @(negedge clk);
      check("R1 valid in reset", int'(sample_valid), 0);
      check("R1 ssb in reset", int'(ssb_out), 0);
      check("R1 dac in reset", int'(dac_out), 127);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 valid after reset", int'(sample_valid), 0);
      check("R1 dac after reset", int'(dac_out), 127);

      run(1'b0, 1024, 400, "R4 R5 R6 R7 R8 phase0");
      run(1'b1, 1024, 400, "R4 R6 R7 R8 phase1");
      run(1'b0, 512, 200, "R9 half");
      run(1'b1, 0, 100, "R9 zero");
      run(1'b0, 2047, 200, "R9 clamp");
      run(1'b1, 1, 50, "R9 tiny");
      for (int k = 0; k < 300; k++)
         step(k[0] ^ k[2], k[1], 700, "R3 R6 gaps");
      run(1'b1, 1500, 200, "R7 R9 tail");
      for (int k = 0; k < 4; k++) step(1'b0, 1'b0, 0, "R2 drain");
      check("R2 all samples out", n_out, n_in);

      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      #1000000;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule